// File: doc/BRIEF.md
# Serial Debug Command and Data Shifter

This block is the target-side serial engine that an external debug controller talks to. Each transaction begins with an 8-bit command shifted in on a serial clock. The low seven bits pick one of the target's debug registers. The top bit picks the direction. A data word follows, whose length depends on the chosen register and lies between 16 and 128 bits. It is shifted in for a write, or shifted out for a read. Both the command and the data travel least significant bit first.

The serial clock, framing and data inputs are sampled by the block's own system clock, and rising edges of the serial clock are detected after a synchroniser. A state machine walks through four states. S_IDLE waits for framing while the target is in debug mode. S_CMD_SHIFT collects the 8 command bits. S_DATA_SHIFT moves the data word. S_WAIT_ACK holds off further traffic until the processor reports that a command has executed. The transitions are:
- S_IDLE to S_CMD_SHIFT when framing is high and debug mode is active.
- S_CMD_SHIFT to S_DATA_SHIFT on the eighth command edge.
- S_CMD_SHIFT or S_DATA_SHIFT to S_IDLE when framing drops, which aborts the transaction.
- S_DATA_SHIFT to S_IDLE, or to S_WAIT_ACK for registers that need acknowledgement, on the final data edge.
- S_WAIT_ACK to S_IDLE when execution done is seen.

Register contents live outside the block. For a write, the block issues a one-cycle write strobe with the aligned word after the final data bit. For a read, it issues a one-cycle read strobe and loads the returned word into its shifter. The acknowledge output tells the controller when it may proceed.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset the machine is in S_IDLE, `tdo_o` is 0, and no write or read strobe is issued.
- R2: The command is shifted LSB first. Command bit 7 set to 1 means a read and 0 means a write. Bits [6:0] select the register, and `reg_sel_o` presents that index from the end of the command phase.
- R3: Register index k below 8 has a data length of 16*(k+1) bits, so index 0 has 16 bits and index 7 has 128 bits.
- R4: A write delivers the data bits LSB first as a word on `reg_wdata_o`, right-aligned and with unused upper bits zero. It does so with exactly one `reg_wr_o` pulse, issued only after the final data bit and never before it.
- R5: A read pulses `reg_rd_o` once after the command phase. `tdo_o` then presents the returned word LSB first: bit i is valid before the (i+1)-th data-phase rising edge. Bits above the register length are masked, and `tdo_o` is 0 outside S_DATA_SHIFT.
- R6: `ack_o` is low whenever `dbg_mode_i` is low. While debug mode is inactive, framing and serial clocks start no transaction and cause no strobe.
- R7: Indices 4 to 7 need acknowledgement. After their data phase the machine holds S_WAIT_ACK with `ack_o` low and ignores serial clocks, until `exec_done_i` returns it to S_IDLE with `ack_o` high. Indices 0 to 3 leave `ack_o` high.
- R8: Indices 8 and above are reserved. They use a 16-bit data phase, writes issue no strobe, reads issue no strobe and shift out zeros, and they never wait for acknowledgement.
- R9: Dropping `frame_i` during the command or data phase returns to S_IDLE with no write strobe. The next framed command then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_mode_i | input | 1 | Target has entered debug mode |
| frame_i | input | 1 | Transaction framing from the controller |
| tck_i | input | 1 | Serial clock; rising edges shift |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| ack_o | output | 1 | Ready / acknowledge to the controller |
| exec_done_i | input | 1 | Processor reports command execution |
| reg_sel_o | output | 7 | Selected register index |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 128 | Aligned write word |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 128 | Read word for the selected register |

## Verification
The hardest condition to reach is S_WAIT_ACK with stray serial clocks arriving. It only occurs after a complete, correctly timed data phase to one of the acknowledge-requiring registers. The stimulus therefore sweeps every register index for both a full write and a full read, with the bench computing each length as 16*(k+1). For indices 4 to 7 it then deliberately toggles the serial clock with data present before raising execution done. Any miscount of the data length also desynchronises every later transaction in the sweep, so a length fault cannot hide.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        S_IDLE       = 2'd0,
        S_CMD_SHIFT  = 2'd1,
        S_DATA_SHIFT = 2'd2,
        S_WAIT_ACK   = 2'd3
    } dbg_state_t;

endpackage

// File: rtl/dbg_edge_sync.sv
module dbg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_i,
    input  logic tdi_i,
    output logic rise_o,
    output logic tdi_o
);
    // tck chain has one extra stage to detect the rising edge
    logic [STAGES:0]   tck_q;
    logic [STAGES-1:0] tdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck_q <= '0;
            tdi_q <= '0;
        end else begin
            tck_q <= {tck_q[STAGES-1:0], tck_i};
            tdi_q <= {tdi_q[STAGES-2:0], tdi_i};
        end
    end

    // data is taken from the same stage as the edge
    assign rise_o = tck_q[STAGES-1] & ~tck_q[STAGES];
    assign tdi_o  = tdi_q[STAGES-1];

endmodule

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode #(
    parameter int CMD_W     = 8,
    parameter int NREG      = 8,
    parameter int UNIT_W    = 16,
    parameter int MAX_W     = 128,
    parameter int ACK_FIRST = 4,
    parameter int LEN_W     = 8,
    parameter int SEL_W     = 7
) (
    input  logic [CMD_W-1:0] cmd_i,
    output logic             rd_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             valid_o,
    output logic [LEN_W-1:0] len_o,
    output logic             need_ack_o
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [LEN_W-1:0] len_tab [NREG];
    logic [IDX_W-1:0] idx;

    // length table: one entry per implemented register
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_len
            assign len_tab[g] = LEN_W'(UNIT_W * (g + 1));
        end
    endgenerate

    assign rd_o       = cmd_i[CMD_W-1];
    assign sel_o      = cmd_i[SEL_W-1:0];
    assign idx        = cmd_i[IDX_W-1:0];
    assign valid_o    = (32'(cmd_i[SEL_W-1:0]) < NREG);
    assign len_o      = valid_o ? len_tab[idx] : LEN_W'(UNIT_W);
    assign need_ack_o = valid_o && (32'(cmd_i[SEL_W-1:0]) >= ACK_FIRST);

endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg #(
    parameter int MAX_W = 128,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [MAX_W-1:0] load_val_i,
    input  logic             shift_i,
    input  logic             sin_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             sout_o,
    output logic [MAX_W-1:0] aligned_o
);
    logic [MAX_W-1:0] q;
    logic [MAX_W-1:0] nxt;
    logic [LEN_W-1:0] shamt;

    // serial input enters at the top, serial output leaves at bit 0
    assign nxt   = {sin_i, q[MAX_W-1:1]};
    assign shamt = LEN_W'(MAX_W) - len_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_i) begin
            q <= load_val_i;
        end else if (shift_i) begin
            q <= nxt;
        end
    end

    assign sout_o    = q[0];
    // word as it stands after the current shift, right-aligned to len
    assign aligned_o = nxt >> shamt;

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbg_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int NREG        = 8,
    parameter int UNIT_W      = 16,
    parameter int MAX_W       = 128,
    parameter int ACK_FIRST   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode_i,
    input  logic              frame_i,
    input  logic              tck_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    output logic              ack_o,
    input  logic              exec_done_i,
    output logic [CMD_W-2:0]  reg_sel_o,
    output logic              reg_wr_o,
    output logic [MAX_W-1:0]  reg_wdata_o,
    output logic              reg_rd_o,
    input  logic [MAX_W-1:0]  reg_rdata_i
);
    localparam int SEL_W = CMD_W - 1;
    localparam int LEN_W = $clog2(MAX_W + 1);
    localparam logic [LEN_W-1:0] CMD_LAST = LEN_W'(CMD_W - 1);

    dbg_state_t state_q, state_d;

    logic              edge_s, tdi_s;
    logic [LEN_W-1:0]  cnt_q;
    logic [CMD_W-1:0]  cmd_q, cmd_nxt;

    // decoded fields of the command being completed
    logic              dec_rd, dec_valid, dec_need;
    logic [SEL_W-1:0]  dec_sel;
    logic [LEN_W-1:0]  dec_len;

    // latched transaction attributes
    logic              rd_q, valid_q, need_q, fetch_q, wr_q;
    logic [SEL_W-1:0]  sel_q;
    logic [LEN_W-1:0]  len_q;
    logic [MAX_W-1:0]  wdata_q;

    logic              cmd_done, data_edge, data_done;
    logic              sh_load, sh_shift, sh_sin, sh_out;
    logic [MAX_W-1:0]  sh_aligned, low_mask, load_val;

    dbg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tck_i  (tck_i),
        .tdi_i  (tdi_i),
        .rise_o (edge_s),
        .tdi_o  (tdi_s)
    );

    assign cmd_nxt = {tdi_s, cmd_q[CMD_W-1:1]};

    dbg_cmd_decode #(
        .CMD_W     (CMD_W),
        .NREG      (NREG),
        .UNIT_W    (UNIT_W),
        .MAX_W     (MAX_W),
        .ACK_FIRST (ACK_FIRST),
        .LEN_W     (LEN_W),
        .SEL_W     (SEL_W)
    ) u_dec (
        .cmd_i      (cmd_nxt),
        .rd_o       (dec_rd),
        .sel_o      (dec_sel),
        .valid_o    (dec_valid),
        .len_o      (dec_len),
        .need_ack_o (dec_need)
    );

    assign cmd_done  = (state_q == S_CMD_SHIFT) && frame_i && edge_s && (cnt_q == CMD_LAST);
    assign data_edge = (state_q == S_DATA_SHIFT) && frame_i && edge_s;
    assign data_done = data_edge && (cnt_q == len_q - LEN_W'(1));

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (frame_i && dbg_mode_i) state_d = S_CMD_SHIFT;
            end
            S_CMD_SHIFT: begin
                if (!frame_i)      state_d = S_IDLE;
                else if (cmd_done) state_d = S_DATA_SHIFT;
            end
            S_DATA_SHIFT: begin
                if (!frame_i)       state_d = S_IDLE;
                else if (data_done) state_d = need_q ? S_WAIT_ACK : S_IDLE;
            end
            S_WAIT_ACK: begin
                if (exec_done_i) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state register and bit counter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (edge_s && (state_q == S_CMD_SHIFT || state_q == S_DATA_SHIFT)) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            if (state_q == S_CMD_SHIFT && edge_s) begin
                cmd_q <= cmd_nxt;
            end
        end
    end

    // ---------------- shift datapath ----------------
    assign low_mask = {MAX_W{1'b1}} >> (LEN_W'(MAX_W) - len_q);
    assign load_val = valid_q ? (reg_rdata_i & low_mask) : '0;
    assign sh_load  = fetch_q && rd_q;
    assign sh_shift = data_edge;
    assign sh_sin   = rd_q ? 1'b0 : tdi_s;

    dbg_shift_reg #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (load_val),
        .shift_i    (sh_shift),
        .sin_i      (sh_sin),
        .len_i      (len_q),
        .sout_o     (sh_out),
        .aligned_o  (sh_aligned)
    );

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            valid_q <= 1'b0;
            need_q  <= 1'b0;
            sel_q   <= '0;
            len_q   <= LEN_W'(UNIT_W);
            fetch_q <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            fetch_q <= cmd_done;
            wr_q    <= data_done && !rd_q && valid_q;
            if (cmd_done) begin
                rd_q    <= dec_rd;
                valid_q <= dec_valid;
                need_q  <= dec_need;
                sel_q   <= dec_sel;
                len_q   <= dec_len;
            end
            if (data_done && !rd_q && valid_q) begin
                wdata_q <= sh_aligned;
            end
        end
    end

    always_comb begin
        tdo_o       = (state_q == S_DATA_SHIFT) && rd_q && sh_out;
        ack_o       = dbg_mode_i && (state_q != S_WAIT_ACK);
        reg_sel_o   = sel_q;
        reg_wr_o    = wr_q;
        reg_wdata_o = wdata_q;
        reg_rd_o    = fetch_q && rd_q && valid_q;
    end

endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk
    import dbg_pkg::*;
#(
    parameter int SEL_W = 7,
    parameter int NREG  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input dbg_state_t       state,
    input logic             dbg_mode_i,
    input logic             exec_done_i,
    input logic             ack_o,
    input logic             tdo_o,
    input logic             reg_wr_o,
    input logic             reg_rd_o,
    input logic [SEL_W-1:0] reg_sel_o
);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !dbg_mode_i) |=> (state == S_IDLE));

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ACK && !exec_done_i) |=> (state == S_WAIT_ACK));

    p_wait_noack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ACK) |-> !ack_o);

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    p_wr_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> ($past(state) == S_DATA_SHIFT));

    p_wr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> (32'(reg_sel_o) < NREG));

    p_tdo_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_DATA_SHIFT) |-> !tdo_o);

    p_rd_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |-> (state == S_DATA_SHIFT));

endmodule

bind dbg_serial_port dbg_serial_port_chk #(.SEL_W(SEL_W), .NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .dbg_mode_i  (dbg_mode_i),
    .exec_done_i (exec_done_i),
    .ack_o       (ack_o),
    .tdo_o       (tdo_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_sel_o   (reg_sel_o)
);

// File: tb/sim_dbg_serial_port.sv
module sim_dbg_serial_port;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dbg_mode = 1'b0;
    logic         frame = 1'b0;
    logic         tck = 1'b0;
    logic         tdi = 1'b0;
    logic         exec_done = 1'b0;
    logic         tdo, ack, reg_wr, reg_rd;
    logic [6:0]   reg_sel;
    logic [127:0] reg_wdata, reg_rdata;

    logic [127:0] mem [8];
    logic [127:0] last_wdata;
    logic [6:0]   last_sel;
    int           wr_cnt = 0;
    int           rd_cnt = 0;
    int           errors = 0;
    int           checks = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    dbg_serial_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_mode_i  (dbg_mode),
        .frame_i     (frame),
        .tck_i       (tck),
        .tdi_i       (tdi),
        .tdo_o       (tdo),
        .ack_o       (ack),
        .exec_done_i (exec_done),
        .reg_sel_o   (reg_sel),
        .reg_wr_o    (reg_wr),
        .reg_wdata_o (reg_wdata),
        .reg_rd_o    (reg_rd),
        .reg_rdata_i (reg_rdata)
    );

    // bench model of the register file; all words start nonzero
    assign reg_rdata = mem[reg_sel[2:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= ~128'h0;
        end else begin
            if (reg_wr) begin
                mem[reg_sel[2:0]] <= reg_wdata;
                last_wdata <= reg_wdata;
                last_sel   <= reg_sel;
                wr_cnt     <= wr_cnt + 1;
            end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] msk(input int len);
        return (len >= 128) ? ~128'h0 : ((128'h1 << len) - 128'h1);
    endfunction

    function automatic logic [127:0] pat(input int k, input logic [31:0] salt);
        logic [127:0] p;
        for (int j = 0; j < 4; j++) p[j*32 +: 32] = (32'h9E3779B9 * 32'(k * 4 + j + 1)) ^ salt;
        return p;
    endfunction

    function automatic int reg_len(input int k);
        return (k < 8) ? 16 * (k + 1) : 16;
    endfunction

    task automatic pulse(input logic b);
        tdi = b;
        @(negedge clk);
        tck = 1'b1;
        repeat (4) @(negedge clk);
        tck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) pulse(c[i]);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [127:0] wd, input int len,
                        output logic [127:0] rd, output int wr_before_last);
        rd = '0;
        wr_before_last = wr_cnt;
        send_cmd(c);
        for (int i = 0; i < len; i++) begin
            rd[i] = tdo;
            if (i == len - 1) wr_before_last = wr_cnt;
            pulse(wd[i]);
        end
    endtask

    task automatic finish_wait(input int k);
        // acknowledge handling after a transaction to register k
        if (k >= 4 && k < 8) begin
            int w0;
            chk(ack == 1'b0, "R7 ack low in wait", 128'(ack), 128'h0);
            w0 = wr_cnt;
            for (int i = 0; i < 3; i++) pulse(1'b1);
            chk(wr_cnt == w0 && ack == 1'b0, "R7 clocks ignored in wait", 128'(wr_cnt - w0), 128'h0);
            @(negedge clk) exec_done = 1'b1;
            @(negedge clk) exec_done = 1'b0;
            repeat (2) @(negedge clk);
            chk(ack == 1'b1, "R7 ack after exec done", 128'(ack), 128'h1);
        end else begin
            chk(ack == 1'b1, "R7 no wait for plain register", 128'(ack), 128'h1);
        end
    endtask

    logic [127:0] expv [8];

    initial begin
        logic [127:0] rd;
        int early, w0, r0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(tdo == 1'b0, "R1 tdo after reset", 128'(tdo), 128'h0);
        chk(ack == 1'b0, "R1 ack with debug mode off", 128'(ack), 128'h0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes after reset", 128'(wr_cnt + rd_cnt), 128'h0);

        // R6: nothing starts outside debug mode
        frame = 1'b1;
        xfer(8'h00, 128'h1234, 16, rd, early);
        chk(wr_cnt == 0, "R6 no write outside debug mode", 128'(wr_cnt), 128'h0);
        chk(ack == 1'b0, "R6 ack low outside debug mode", 128'(ack), 128'h0);
        frame = 1'b0;
        dbg_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk(ack == 1'b1, "R6 ack on debug mode entry", 128'(ack), 128'h1);
        frame = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4: write sweep over all registers
        for (int k = 0; k < 8; k++) begin
            expv[k] = pat(k, 32'h5A5A_0F0F) & msk(reg_len(k));
            w0 = wr_cnt;
            xfer(8'(k), pat(k, 32'h5A5A_0F0F), reg_len(k), rd, early);
            chk(early == w0, "R4 no write before final bit", 128'(early - w0), 128'h0);
            chk(wr_cnt == w0 + 1, "R4 exactly one write strobe", 128'(wr_cnt - w0), 128'h1);
            chk(last_sel == 7'(k), "R2 register select", 128'(last_sel), 128'(k));
            chk(last_wdata == expv[k], "R3 write word and length", last_wdata, expv[k]);
            finish_wait(k);
        end

        // R5: read sweep over all registers
        for (int k = 0; k < 8; k++) begin
            w0 = wr_cnt;
            r0 = rd_cnt;
            xfer(8'h80 | 8'(k), '0, reg_len(k), rd, early);
            chk(rd == expv[k], "R5 read data LSB first", rd, expv[k]);
            chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R5 one read strobe, no write", 128'(rd_cnt - r0), 128'h1);
            finish_wait(k);
        end

        // R8: reserved indices
        w0 = wr_cnt;
        xfer(8'h09, ~128'h0, 16, rd, early);
        chk(wr_cnt == w0, "R8 reserved write dropped", 128'(wr_cnt - w0), 128'h0);
        chk(ack == 1'b1, "R8 reserved needs no ack", 128'(ack), 128'h1);
        r0 = rd_cnt;
        xfer(8'h8A, '0, 16, rd, early);
        chk(rd == '0, "R8 reserved read zeros", rd, 128'h0);
        chk(rd_cnt == r0, "R8 reserved read no strobe", 128'(rd_cnt - r0), 128'h0);
        expv[1] = pat(1, 32'hC3C3_1111) & msk(32);
        xfer(8'h01, pat(1, 32'hC3C3_1111), 32, rd, early);
        chk(last_wdata == expv[1] && last_sel == 7'd1, "R8 traffic in step after reserved", last_wdata, expv[1]);

        // R9: abort by dropping frame
        w0 = wr_cnt;
        send_cmd(8'h07);
        for (int i = 0; i < 20; i++) pulse(i[0]);
        frame = 1'b0;
        repeat (4) @(negedge clk);
        chk(wr_cnt == w0, "R9 abort issues no write", 128'(wr_cnt - w0), 128'h0);
        chk(ack == 1'b1, "R9 ready after abort", 128'(ack), 128'h1);
        frame = 1'b1;
        repeat (2) @(negedge clk);
        expv[2] = pat(2, 32'h0BAD_F00D) & msk(48);
        xfer(8'h02, pat(2, 32'h0BAD_F00D), 48, rd, early);
        chk(wr_cnt == w0 + 1 && last_wdata == expv[2], "R9 next command after abort", last_wdata, expv[2]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule